// File: doc/BRIEF.md
# Fused Multiply-Add NaN Selector

This block is the NaN-handling front end of a single-precision fused multiply-add that computes (a*b)+c. It classifies each of the three operands as a quiet NaN, a signaling NaN or a non-NaN value. It detects the case where one multiplicand is an infinity and the other is a zero of either sign. From these it picks the value the operation must return: one of the operands (quieted first if it was signaling) or a generated default NaN. It also reports whether the invalid-operation flag must be raised.

A 3-bit policy input chooses one of several priority schemes. A polarity input states whether a set fraction MSB marks a signaling NaN (1) or a quiet NaN (0). A use-first input steers one of the schemes. The surrounding datapath calls the selector only when at least one operand is a NaN. With no NaN present, the code still follows the chosen scheme's fallback. The outputs are registered one cycle after an accepted request.

Top module: `fma_nan_pick`

## Requirements
- R1: The selection output encodes the chosen value as 0 = a, 1 = b, 2 = c and 3 = default NaN. When the code is 0, 1 or 2, the result is that operand, with its sign and payload kept.
- R2: With polarity 0, a NaN (exponent all ones, fraction nonzero) is signaling when fraction bit 22 is 0 and quiet when it is 1. With polarity 1 the meaning of that bit is reversed.
- R3: A selected signaling operand is quieted. With polarity 0, fraction bit 22 is set. With polarity 1, bit 22 is cleared and bit 21 is set.
- R4: The default NaN has sign 0 and an all-ones exponent. With polarity 0 it is 0x7FC00000, and with polarity 1 it is 0x7FBFFFFF.
- R5: Invalid is raised when any operand is a signaling NaN. It is also raised by the infinity-times-zero case under the rules of R6 to R11.
- R6: Policy 0: infinity-times-zero with c a quiet NaN gives the default NaN and invalid. Otherwise the priority is c signaling, a signaling, b signaling, c NaN, a NaN, then b.
- R7: Policy 1 with polarity 1: infinity-times-zero gives the default NaN and invalid. Otherwise the priority is signaling a, b, c, then NaN a, b, then c.
- R8: Policy 1 with polarity 0: infinity-times-zero selects c and raises invalid. Otherwise the priority is signaling c, a, b, then NaN c, a, then b.
- R9: Policy 2: infinity-times-zero selects c and raises invalid. Otherwise the result is a if a is a NaN, else c if c is a NaN, else b.
- R10: Policy 3: the result is always the default NaN, and infinity-times-zero raises invalid.
- R11: Policy 4: infinity-times-zero selects c and raises invalid. Otherwise the order is a, b, c when use-first is 1 and c, b, a when it is 0, and any NaN counts.
- R12: Policies 5, 6 and 7: the result is a if a is a NaN, else b if b is a NaN, else c. Infinity-times-zero alone does not raise invalid.
- R13: Outputs change one clock after a cycle with in_valid high, and out_valid is in_valid delayed by one clock. Outputs hold their value when in_valid is low.
- R14: After reset, out_valid, sel, result and invalid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| policy | input | 3 | Priority scheme select |
| snan_one | input | 1 | 1: set fraction MSB marks a signaling NaN |
| use_first | input | 1 | Order control for policy 4 |
| a | input | 32 | Multiplicand a |
| b | input | 32 | Multiplicand b |
| c | input | 32 | Addend c |
| out_valid | output | 1 | Result strobe |
| sel | output | 2 | Selection code |
| result | output | 32 | Chosen NaN value |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench builds the block with its default 8-bit exponent and 23-bit fraction. At that size every operand can be drawn from five classes: quiet NaN, signaling NaN, infinity, zero and normal. It sweeps all 125 class triples under all eight policy codes, both polarities and both use-first values. This reaches every priority step, every infinity-times-zero rule and both quieting rules. Each operand carries a distinct payload and sign, so a wrong pick shows up in the result as well as in the code.

// File: rtl/fma_nan_pick.sv
module fma_nan_pick #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [2:0]               policy,
  input  logic                     snan_one,
  input  logic                     use_first,
  input  logic [EXP_W+MAN_W:0]     a,
  input  logic [EXP_W+MAN_W:0]     b,
  input  logic [EXP_W+MAN_W:0]     c,
  output logic                     out_valid,
  output logic [1:0]               sel,
  output logic [EXP_W+MAN_W:0]     result,
  output logic                     invalid
);
  localparam int W  = 1 + EXP_W + MAN_W;
  localparam int QB = MAN_W - 1;

  function automatic logic f_nan(input logic [W-1:0] x);
    return (&x[W-2:MAN_W]) && (|x[MAN_W-1:0]);
  endfunction

  function automatic logic f_inf(input logic [W-1:0] x);
    return (&x[W-2:MAN_W]) && !(|x[MAN_W-1:0]);
  endfunction

  function automatic logic f_zero(input logic [W-1:0] x);
    return !(|x[W-2:0]);
  endfunction

  function automatic logic [W-1:0] f_default(input logic p);
    logic [W-1:0] d;
    d = '0;
    d[W-2:MAN_W] = '1;
    if (p) d[QB-1:0] = '1;
    else   d[QB] = 1'b1;
    return d;
  endfunction

  logic [W-1:0] op [3];
  logic [2:0]   nan_v, sig_v, qui_v;
  assign op[0] = a;
  assign op[1] = b;
  assign op[2] = c;

  for (genvar k = 0; k < 3; k++) begin : g_cls
    assign nan_v[k] = f_nan(op[k]);
    assign sig_v[k] = nan_v[k] && (op[k][QB] == snan_one);
    assign qui_v[k] = nan_v[k] && (op[k][QB] != snan_one);
  end

  wire inf_zero = (f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b));

  logic [1:0] pick;
  logic       iz_inv;

  always_comb begin
    pick   = 2'd2;
    iz_inv = 1'b0;
    case (policy)
      3'd0: begin
        if (inf_zero && qui_v[2]) begin pick = 2'd3; iz_inv = 1'b1; end
        else if (sig_v[2]) pick = 2'd2;
        else if (sig_v[0]) pick = 2'd0;
        else if (sig_v[1]) pick = 2'd1;
        else if (qui_v[2]) pick = 2'd2;
        else if (qui_v[0]) pick = 2'd0;
        else               pick = 2'd1;
      end
      3'd1: begin
        if (snan_one) begin
          if (inf_zero)      begin pick = 2'd3; iz_inv = 1'b1; end
          else if (sig_v[0]) pick = 2'd0;
          else if (sig_v[1]) pick = 2'd1;
          else if (sig_v[2]) pick = 2'd2;
          else if (qui_v[0]) pick = 2'd0;
          else if (qui_v[1]) pick = 2'd1;
          else               pick = 2'd2;
        end else begin
          if (inf_zero)      begin pick = 2'd2; iz_inv = 1'b1; end
          else if (sig_v[2]) pick = 2'd2;
          else if (sig_v[0]) pick = 2'd0;
          else if (sig_v[1]) pick = 2'd1;
          else if (qui_v[2]) pick = 2'd2;
          else if (qui_v[0]) pick = 2'd0;
          else               pick = 2'd1;
        end
      end
      3'd2: begin
        if (inf_zero)      begin pick = 2'd2; iz_inv = 1'b1; end
        else if (nan_v[0]) pick = 2'd0;
        else if (nan_v[2]) pick = 2'd2;
        else               pick = 2'd1;
      end
      3'd3: begin
        pick   = 2'd3;
        iz_inv = inf_zero;
      end
      3'd4: begin
        if (inf_zero) begin pick = 2'd2; iz_inv = 1'b1; end
        else if (use_first) pick = nan_v[0] ? 2'd0 : (nan_v[1] ? 2'd1 : 2'd2);
        else                pick = nan_v[2] ? 2'd2 : (nan_v[1] ? 2'd1 : 2'd0);
      end
      default: pick = nan_v[0] ? 2'd0 : (nan_v[1] ? 2'd1 : 2'd2);
    endcase
  end

  logic [W-1:0] chosen, quieted, value;
  assign chosen = (pick == 2'd3) ? '0 : op[pick];

  always_comb begin
    quieted = chosen;
    if (snan_one) begin
      quieted[QB]   = 1'b0;
      quieted[QB-1] = 1'b1;
    end else begin
      quieted[QB]   = 1'b1;
    end
  end

  assign value = (pick == 2'd3) ? f_default(snan_one)
               : (sig_v[pick] ? quieted : chosen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sel       <= 2'd0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sel     <= pick;
        result  <= value;
        invalid <= iz_inv || (|sig_v);
      end
    end
  end

  a_r13_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid))
    else $error("R13 out_valid lag");

  a_r13_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(sel) && $stable(invalid))
    else $error("R13 outputs moved while idle");

  a_r3_never_signaling: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) && f_nan(result) |-> result[QB] != $past(snan_one))
    else $error("R3 signaling NaN escaped");

  a_r10_policy3_default: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && policy == 3'd3 |=> sel == 2'd3)
    else $error("R10 policy 3 not default");

  a_r4_default_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) && sel == 2'd3 |-> result == f_default($past(snan_one)))
    else $error("R4 default NaN pattern");

  a_r5_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (|sig_v) |=> invalid)
    else $error("R5 signaling input without invalid");
endmodule

// File: tb/fma_nan_pick_test.sv
module fma_nan_pick_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  policy = '0;
  logic        snan_one = 1'b0;
  logic        use_first = 1'b0;
  logic [31:0] a = '0, b = '0, c = '0;
  logic        out_valid;
  logic [1:0]  sel;
  logic [31:0] result;
  logic        invalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fma_nan_pick uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .policy(policy),
    .snan_one(snan_one), .use_first(use_first), .a(a), .b(b), .c(c),
    .out_valid(out_valid), .sel(sel), .result(result), .invalid(invalid)
  );

  function automatic bit is_n(input logic [31:0] v);
    return v[30:23] == 8'hFF && v[22:0] != 0;
  endfunction

  function automatic bit is_s(input logic [31:0] v, input bit p);
    return is_n(v) && (v[22] == p);
  endfunction

  function automatic logic [31:0] mk(input int cls, input bit p, input int idx);
    logic [31:0] v;
    logic [22:0] pay;
    pay = 23'(idx + 1);
    case (cls)
      0: v = {1'b0, 8'hFF, (p ? pay : (23'h400000 | pay))};
      1: v = {1'b0, 8'hFF, (p ? (23'h400000 | pay) : pay)};
      2: v = 32'h7F800000;
      3: v = 32'h00000000;
      default: v = 32'h3F800000;
    endcase
    if (idx == 1) v[31] = 1'b1;
    return v;
  endfunction

  task automatic model(input int pl, input bit p, input bit uf,
                       input logic [31:0] xa, input logic [31:0] xb, input logic [31:0] xc,
                       output logic [1:0] es, output logic [31:0] er, output bit ei);
    logic [31:0] x [3];
    int ordo [6];
    int ordm [6];
    int n, fb;
    bit iz, hit;
    x[0] = xa; x[1] = xb; x[2] = xc;
    iz = (xa[30:0] == 31'h7F800000 && xb[30:0] == 0) ||
         (xb[30:0] == 31'h7F800000 && xa[30:0] == 0);
    ei = is_s(xa, p) || is_s(xb, p) || is_s(xc, p);
    es = 2'd2; n = 0; fb = 2; hit = 0;
    if (pl == 0 && iz && is_n(xc) && !is_s(xc, p)) begin es = 3; ei = 1; hit = 1; end
    else if (pl == 1 && p && iz) begin es = 3; ei = 1; hit = 1; end
    else if (pl == 3) begin es = 3; ei = ei || iz; hit = 1; end
    else if ((pl == 1 || pl == 2 || pl == 4) && iz) begin es = 2; ei = 1; hit = 1; end
    if (!hit) begin
      if (pl == 0 || (pl == 1 && !p)) begin
        ordo = '{2, 0, 1, 2, 0, 0}; ordm = '{0, 0, 0, 1, 1, 1}; n = 5; fb = 1;
      end else if (pl == 1) begin
        ordo = '{0, 1, 2, 0, 1, 0}; ordm = '{0, 0, 0, 1, 1, 1}; n = 5; fb = 2;
      end else if (pl == 2) begin
        ordo = '{0, 2, 0, 0, 0, 0}; ordm = '{1, 1, 1, 1, 1, 1}; n = 2; fb = 1;
      end else if (pl == 4 && !uf) begin
        ordo = '{2, 1, 0, 0, 0, 0}; ordm = '{1, 1, 1, 1, 1, 1}; n = 2; fb = 0;
      end else begin
        ordo = '{0, 1, 0, 0, 0, 0}; ordm = '{1, 1, 1, 1, 1, 1}; n = 2; fb = 2;
      end
      es = 2'(fb);
      for (int i = n - 1; i >= 0; i--) begin
        if (ordm[i] == 0 ? is_s(x[ordo[i]], p) : is_n(x[ordo[i]])) es = 2'(ordo[i]);
      end
    end
    if (es == 3) er = p ? 32'h7FBFFFFF : 32'h7FC00000;
    else begin
      er = x[es];
      if (is_s(er, p)) er = p ? ((er & ~32'h00400000) | 32'h00200000) : (er | 32'h00400000);
    end
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (policy %0d pol %0d uf %0d a %h b %h c %h)",
               req, got, exp, policy, snan_one, use_first, a, b, c);
    end
  endtask

  function automatic string tag(input int pl, input bit p);
    case (pl)
      0: return "R6";
      1: return p ? "R7" : "R8";
      2: return "R9";
      3: return "R10";
      4: return "R11";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0]  es;
    logic [31:0] er, last_r;
    bit          ei;
    repeat (3) @(negedge clk);
    check("R14 out_valid", 32'(out_valid), 0);
    check("R14 sel", 32'(sel), 0);
    check("R14 result", result, 0);
    check("R14 invalid", 32'(invalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int pl = 0; pl < 8; pl++)
      for (int p = 0; p < 2; p++)
        for (int uf = 0; uf < 2; uf++)
          for (int t = 0; t < 125; t++) begin
            policy = 3'(pl); snan_one = p[0]; use_first = uf[0];
            a = mk(t % 5, p[0], 0); b = mk((t / 5) % 5, p[0], 1); c = mk(t / 25, p[0], 2);
            in_valid = 1'b1;
            model(pl, p[0], uf[0], a, b, c, es, er, ei);
            @(negedge clk);
            check("R13 out_valid", 32'(out_valid), 1);
            check({tag(pl, p[0]), " R1 sel"}, 32'(sel), 32'(es));
            check({tag(pl, p[0]), " R2 R3 R4 result"}, result, er);
            check({tag(pl, p[0]), " R5 invalid"}, 32'(invalid), 32'(ei));
          end
    last_r = result;
    in_valid = 1'b0;
    policy = 3'd3; a = mk(1, 0, 0); b = 32'h7F800000; c = 32'h0;
    @(negedge clk);
    check("R13 idle out_valid", 32'(out_valid), 0);
    check("R13 idle hold", result, last_r);
    @(negedge clk);
    check("R13 idle hold 2", result, last_r);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule